// File: doc/BRIEF.md
# Oscillator Settling Timer

This block measures the start-up interval of an external crystal oscillator before the system is allowed to switch onto it. It runs on the oscillator clock itself, so only real oscillator edges count and time before the crystal starts toggling is never counted. Counting restarts in two cases. The first is when the stop control is released. The second is when a deep-sleep exit pulse arrives while the oscillator is already running.

A 3-bit selection field picks one of eight power-of-two cycle thresholds. These are 2^8, 2^9, 2^10, 2^11, 2^13, 2^15, 2^17 and 2^18 cycles. The count stops at the selected threshold, and a ready flag rises when it gets there. A read-only status byte gives one progress bit per threshold. Software writes the selection only while the oscillator is stopped. While it runs, such writes are dropped.

The parameter `EXP_OFFSET` lowers every exponent by the same amount, so a small configuration runs the full table at reduced cycle counts.

Top module: `osc_settle_timer`

## Requirements
- R1: Register address 0 holds the selection field in bits 2:0, and bits 7:3 of that byte read as 0. Address 1 is the read-only status byte, and writes to it have no effect.
- R2: After reset the selection reads 0x07, the status reads 0x00 and `settled` is 0.
- R3: Select code c maps to a threshold of 2^(E[c]-EXP_OFFSET) cycles, where E = {8,9,10,11,13,15,17,18} for c = 0..7.
- R4: Call the first rising edge at which `osc_stop` is sampled low the start edge. `settled` rises after exactly T further rising edges, where T is the selected threshold.
- R5: A `wake_pulse` sampled high while `osc_stop` is low clears the count, the status and `settled` at that edge. `settled` then rises after exactly T further edges.
- R6: A `wake_pulse` sampled while `osc_stop` is high has no effect, and the next start still takes exactly T edges.
- R7: Once the threshold is reached, the count freezes. `settled` and the status stay constant while running, and the count never passes the largest threshold.
- R8: A selection write sampled while `osc_stop` is low is ignored. The readback and the running threshold keep their old value.
- R9: Setting `osc_stop` high clears the count, the status and `settled` at the next edge.
- R10: Status bit i is 1 exactly when the count is at least the threshold of code i. Bits above the selected code therefore stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_stop | input | 1 | 1 = oscillator stopped, 0 = running |
| wake_pulse | input | 1 | Deep-sleep exit pulse |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = selection, 1 = status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| settled | output | 1 | Selected settling time has elapsed |

## Verification
Every select code is swept with `EXP_OFFSET` = 7. After each edge of each run, the status byte and `settled` are compared with the arithmetic threshold table. This separates the table entries from one another and exposes any off-by-one error at the start edge. A long hold after settling, a mid-count stop and a wake pulse during a run are then applied; these tell a frozen counter from a wrapping one and a restart from a continuation. A wake pulse while stopped and a selection write while running are then applied, and each is checked for leaving the next count unchanged.

// File: rtl/osc_settle_pkg.sv
package osc_settle_pkg;
   localparam int SEL_W   = 3;
   localparam int NCODES  = 1 << SEL_W;
   localparam int REG_W   = 8;
   localparam int MAX_EXP = 18;

   // Exponent of the cycle threshold for each select code
   function automatic int code_exp(input int code);
      case (code)
         0: return 8;
         1: return 9;
         2: return 10;
         3: return 11;
         4: return 13;
         5: return 15;
         6: return 17;
         default: return 18;
      endcase
   endfunction

   function automatic int cnt_width(input int off);
      return MAX_EXP - off + 1;
   endfunction
endpackage

// File: rtl/osc_settle_regs.sv
module osc_settle_regs
   import osc_settle_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             addr,
   input  logic [REG_W-1:0] wdata,
   input  logic             wr_allow,
   input  logic [REG_W-1:0] status,
   output logic [SEL_W-1:0] sel,
   output logic [REG_W-1:0] rdata
);
   localparam logic [SEL_W-1:0] SEL_RST = SEL_W'(NCODES - 1);

   logic unused_wdata_hi;
   assign unused_wdata_hi = ^wdata[REG_W-1:SEL_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sel <= SEL_RST;
      else if (wr_en && !addr && wr_allow)
         sel <= wdata[SEL_W-1:0];
   end

   always_comb begin
      if (addr)
         rdata = status;
      else
         rdata = {{(REG_W-SEL_W){1'b0}}, sel};
   end
endmodule

// File: rtl/osc_settle_cnt.sv
module osc_settle_cnt #(
   parameter int CNT_W = 19
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [CNT_W-1:0] target,
   output logic [CNT_W-1:0] cnt,
   output logic             done
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   assign done = (cnt == target);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run || restart)
         cnt <= '0;
      else if (!done && cnt != CNT_MAX)
         cnt <= cnt + CNT_W'(1);
   end
endmodule

// File: rtl/osc_settle_status.sv
module osc_settle_status
   import osc_settle_pkg::*;
#(
   parameter int EXP_OFFSET = 0,
   parameter int CNT_W      = 19
) (
   input  logic [CNT_W-1:0]  cnt,
   output logic [NCODES-1:0] status
);
   for (genvar i = 0; i < NCODES; i++) begin : g_cmp
      localparam logic [CNT_W-1:0] THR = CNT_W'(1) << (code_exp(i) - EXP_OFFSET);
      assign status[i] = (cnt >= THR);
   end
endmodule

// File: rtl/osc_settle_timer.sv
module osc_settle_timer
   import osc_settle_pkg::*;
#(
   parameter int EXP_OFFSET = 0
) (
   input  logic             clk_osc,
   input  logic             rst_n,
   input  logic             osc_stop,
   input  logic             wake_pulse,
   input  logic             reg_wr_en,
   input  logic             reg_addr,
   input  logic [7:0]       reg_wdata,
   output logic [7:0]       reg_rdata,
   output logic             settled
);
   localparam int CNT_W = cnt_width(EXP_OFFSET);

   if (EXP_OFFSET < 0 || EXP_OFFSET > 7) begin : g_bad_offset
      $error("EXP_OFFSET must lie in 0..7");
   end
   if (NCODES != REG_W) begin : g_bad_width
      $error("status byte needs one bit per code");
   end

   logic              stop_q;
   logic              restart;
   logic [SEL_W-1:0]  sel_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  target;
   logic [NCODES-1:0] status_w;

   always_ff @(posedge clk_osc or negedge rst_n) begin
      if (!rst_n) stop_q <= 1'b1;
      else        stop_q <= osc_stop;
   end

   assign restart = !osc_stop && (stop_q || wake_pulse);

   always_comb
      target = CNT_W'(1) << (code_exp(int'(sel_q)) - EXP_OFFSET);

   osc_settle_regs u_regs (
      .clk      (clk_osc),
      .rst_n    (rst_n),
      .wr_en    (reg_wr_en),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .wr_allow (osc_stop),
      .status   (status_w),
      .sel      (sel_q),
      .rdata    (reg_rdata)
   );

   osc_settle_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk_osc),
      .rst_n   (rst_n),
      .run     (!osc_stop),
      .restart (restart),
      .target  (target),
      .cnt     (cnt_q),
      .done    (settled)
   );

   osc_settle_status #(.EXP_OFFSET(EXP_OFFSET), .CNT_W(CNT_W)) u_status (
      .cnt    (cnt_q),
      .status (status_w)
   );
endmodule

// File: rtl/osc_settle_chk.sv
module osc_settle_chk
   import osc_settle_pkg::*;
#(
   parameter int EXP_OFFSET = 0,
   parameter int CNT_W      = 19
) (
   input logic              clk,
   input logic              rst_n,
   input logic              osc_stop,
   input logic              wake,
   input logic [SEL_W-1:0]  sel,
   input logic [CNT_W-1:0]  cnt,
   input logic [NCODES-1:0] status,
   input logic              settled
);
   localparam logic [CNT_W-1:0] TOP = CNT_W'(1) << (MAX_EXP - EXP_OFFSET);

   logic stop_d;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stop_d <= 1'b1;
      else        stop_d <= osc_stop;
   end

   AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_stop |=> $stable(sel)); // R8
   AST_STOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      osc_stop |=> (cnt == '0 && status == '0 && !settled)); // R9
   AST_WAKE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (wake && !osc_stop) |=> (cnt == '0 && !settled)); // R5
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!osc_stop && !wake && !stop_d && !settled) |=> cnt == $past(cnt) + CNT_W'(1)); // R4
   AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (settled && !osc_stop && !wake && !stop_d) |=> (settled && $stable(status))); // R7
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= TOP); // R7
   AST_STATUS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      settled |-> status[sel]); // R10
endmodule

bind osc_settle_timer osc_settle_chk #(.EXP_OFFSET(EXP_OFFSET), .CNT_W(CNT_W)) u_chk (
   .clk      (clk_osc),
   .rst_n    (rst_n),
   .osc_stop (osc_stop),
   .wake     (wake_pulse),
   .sel      (sel_q),
   .cnt      (cnt_q),
   .status   (status_w),
   .settled  (settled)
);

// File: tb/osc_settle_timer_bench.sv
`timescale 1ns/1ps
module osc_settle_timer_bench;
   localparam int OFF = 7;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       osc_stop = 1'b1;
   logic       wake_pulse = 1'b0;
   logic       reg_wr_en = 1'b0;
   logic       reg_addr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       settled;

   int checks = 0;
   int errors = 0;
   int exps[8] = '{8, 9, 10, 11, 13, 15, 17, 18};

   always #4 clk = ~clk;

   osc_settle_timer #(.EXP_OFFSET(OFF)) u_osc_settle_timer (
      .clk_osc(clk), .rst_n(rst_n), .osc_stop(osc_stop), .wake_pulse(wake_pulse),
      .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .settled(settled)
   );

   function automatic int thr(input int c);
      return 1 << (exps[c] - OFF);
   endfunction

   function automatic logic [7:0] mask_for(input int n);
      logic [7:0] m = '0;
      for (int i = 0; i < 8; i++) if (n >= thr(i)) m[i] = 1'b1;
      return m;
   endfunction

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic read_reg(input logic a, output logic [7:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic write_sel(input logic [7:0] d);
      reg_addr = 1'b0; reg_wdata = d; reg_wr_en = 1'b1;
      tick();
      reg_wr_en = 1'b0;
   endtask

   // Checks status and settled against a count n within a run on code c
   task automatic check_state(input string req, input int c, input int n);
      logic [7:0] st;
      int lim;
      lim = (n > thr(c)) ? thr(c) : n;
      read_reg(1'b1, st);
      check8(req, st, mask_for(lim));
      check8(req, {7'b0, settled}, {7'b0, lim == thr(c)});
   endtask

   initial begin
      logic [7:0] d;
      repeat (3) tick();
      // R2 reset state
      read_reg(1'b0, d); check8("R2 sel", d, 8'h07);
      read_reg(1'b1, d); check8("R2 status", d, 8'h00);
      check8("R2 settled", {7'b0, settled}, 8'h00);
      rst_n = 1'b1;
      tick();

      // R1 R3 R4 R7 R9 R10 sweep over all codes
      for (int c = 0; c < 8; c++) begin
         write_sel(8'hF8 | 8'(c));
         read_reg(1'b0, d); check8("R1 readback", d, 8'(c));
         reg_addr = 1'b1; reg_wdata = 8'hFF; reg_wr_en = 1'b1; tick(); reg_wr_en = 1'b0;
         read_reg(1'b1, d); check8("R1 status write ignored", d, 8'h00);
         osc_stop = 1'b0;
         tick();   // start edge
         for (int n = 0; n <= thr(c); n++) begin
            check_state("R3 R4 R10 count", c, n);
            if (n < thr(c)) tick();
         end
         for (int k = 1; k <= 6; k++) begin
            tick();
            check_state("R7 frozen", c, thr(c) + k);
         end
         osc_stop = 1'b1;
         tick();
         read_reg(1'b1, d); check8("R9 stop clears status", d, 8'h00);
         check8("R9 stop clears settled", {7'b0, settled}, 8'h00);
      end

      // R9 stop mid-count then fresh count
      write_sel(8'h03);
      osc_stop = 1'b0; tick();
      repeat (10) tick();
      check_state("R9 mid", 3, 10);
      osc_stop = 1'b1; tick();
      check_state("R9 cleared", 3, 0);
      osc_stop = 1'b0; tick();
      for (int n = 0; n <= thr(3); n++) begin
         check_state("R9 recount", 3, n);
         if (n < thr(3)) tick();
      end

      // R5 wake restart after settling and during count
      wake_pulse = 1'b1; tick(); wake_pulse = 1'b0;
      check_state("R5 wake clears", 3, 0);
      repeat (5) tick();
      check_state("R5 partial", 3, 5);
      wake_pulse = 1'b1; tick(); wake_pulse = 1'b0;
      for (int n = 0; n <= thr(3); n++) begin
         check_state("R5 restart count", 3, n);
         if (n < thr(3)) tick();
      end

      // R6 wake while stopped has no effect
      osc_stop = 1'b1; tick();
      write_sel(8'h01);
      wake_pulse = 1'b1; tick(); wake_pulse = 1'b0;
      check_state("R6 stopped", 1, 0);
      osc_stop = 1'b0; tick();
      for (int n = 0; n <= thr(1); n++) begin
         check_state("R6 count", 1, n);
         if (n < thr(1)) tick();
      end

      // R8 write while running ignored
      osc_stop = 1'b1; tick();
      write_sel(8'h02);
      osc_stop = 1'b0; tick();
      repeat (2) tick();
      write_sel(8'h05);
      read_reg(1'b0, d); check8("R8 sel kept", d, 8'h02);
      check_state("R8 mid", 2, 3);
      for (int n = 3; n <= thr(2) + 3; n++) begin
         check_state("R8 old threshold", 2, n);
         tick();
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule